// File: doc/BRIEF.md
# Registered-Backpressure Link Pipeline

This block is a string of pipeline stages placed on a long wire between two routers of an on-chip network. Each stage registers the flit and its valid bit going forward, and it also registers the backpressure bit going backward. Because the backward bit is registered, a sender keeps sending for one cycle after a receiver has decided to stop. To absorb that extra flit, every stage has two flit slots. The main slot carries traffic in the normal case. The backup slot catches the flit that was already on its way when backpressure arrived.

Control logic in each stage drives a write enable for each slot and a select that picks which slot drives the output. The stage raises backpressure toward its sender while the backup slot is occupied. It drops backpressure once that slot has drained. The number of stages in the string and the flit width are parameters. A flit moves across an interface on a clock edge where valid is high and backpressure is low. A sender that sees backpressure high keeps its flit on the wires until backpressure drops.

Top module: `lsp_chain`

## Requirements
- R1: A synchronous reset empties every slot, so `dn_valid` and `up_stall` read 0 after it.
- R2: With `dn_stall` low, a flit accepted at an edge appears on `dn_valid`/`dn_data` after exactly STAGES clock edges.
- R3: With `dn_stall` held low, a back-to-back stream leaves one flit per cycle with no bubbles, and `up_stall` stays low the whole time.
- R4: While `dn_stall` is high and `dn_valid` is high, the next cycle still shows `dn_valid` high with unchanged `dn_data`.
- R5: Under a held `dn_stall`, the chain takes in exactly 2*STAGES flits (two per stage) before it refuses input.
- R6: `up_stall` rises only in the cycle after a flit was offered on `up_valid`, and it falls again once downstream backpressure is released and the chain drains.
- R7: A value on `up_valid`/`up_data` at an edge where `up_stall` is high is not taken; it never appears at the output.
- R8: Under any pattern of `dn_stall`, flits leave in the order they entered, with none lost and none duplicated, and `dn_valid` only drops after an edge where `dn_stall` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_data | input | W | Flit from the sender |
| up_valid | input | 1 | Sender offers a flit |
| up_stall | output | 1 | Registered backpressure toward the sender |
| dn_data | output | W | Flit toward the receiver |
| dn_valid | output | 1 | A flit is presented to the receiver |
| dn_stall | input | 1 | Backpressure from the receiver |

## Verification
The chain is tried with a single isolated flit, which measures the pure forward latency, and with an unbroken stream and no backpressure, which exposes any bubble or any false stall. A long held backpressure fills every slot and counts how many flits get in, which tells a missing backup slot apart from an extra one. Pseudo-random backpressure, with garbage driven on the input while the chain refuses it, checks ordering against a scoreboard and shows whether a refused input leaks in or a caught flit goes missing.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    // Registered control state of one stage.
    typedef struct packed {
        logic v_main;   // main slot holds a flit
        logic v_bak;    // backup slot holds a flit
        logic sel;      // 1: backup slot is the head
        logic stall;    // registered backpressure to the sender
    } lsp_ctl_t;

    localparam lsp_ctl_t LSP_CTL_RESET = '{v_main: 1'b0, v_bak: 1'b0, sel: 1'b0, stall: 1'b0};

endpackage

// File: rtl/lsp_slot.sv
module lsp_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (en) q_d = d;
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    assign q = q_q;

endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
    import lsp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_stall,
    output logic en_main,
    output logic en_bak,
    output logic sel,
    output logic out_valid,
    output logic in_stall
);

    lsp_ctl_t st_d, st_q;

    logic head_v, pop, keep_main, keep_bak, take;

    always_comb begin
        st_d      = st_q;
        head_v    = st_q.sel ? st_q.v_bak : st_q.v_main;
        pop       = head_v && !out_stall;
        keep_main = st_q.v_main && !(pop && !st_q.sel);
        keep_bak  = st_q.v_bak  && !(pop &&  st_q.sel);
        take      = in_valid && !st_q.stall;

        // main slot first; backup only when main stays occupied
        en_main   = take && !keep_main;
        en_bak    = take &&  keep_main;

        st_d.v_main = keep_main | en_main;
        st_d.v_bak  = keep_bak  | en_bak;

        // head is the oldest surviving flit
        if (keep_main && keep_bak) st_d.sel = st_q.sel;
        else if (keep_bak)         st_d.sel = 1'b1;
        else                       st_d.sel = 1'b0;

        // hold the sender off while the backup slot is in use
        st_d.stall = st_d.v_bak;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LSP_CTL_RESET;
        else     st_q <= st_d;
    end

    assign sel       = st_q.sel;
    assign out_valid = head_v;
    assign in_stall  = st_q.stall;

endmodule

// File: rtl/lsp_stage.sv
module lsp_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_stall,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_stall
);

    logic         en_main, en_bak, sel;
    logic [W-1:0] q_main, q_bak;

    lsp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_stall (out_stall),
        .en_main   (en_main),
        .en_bak    (en_bak),
        .sel       (sel),
        .out_valid (out_valid),
        .in_stall  (in_stall)
    );

    lsp_slot #(.W(W)) u_main (
        .clk (clk),
        .en  (en_main),
        .d   (in_data),
        .q   (q_main)
    );

    lsp_slot #(.W(W)) u_bak (
        .clk (clk),
        .en  (en_bak),
        .d   (in_data),
        .q   (q_bak)
    );

    assign out_data = sel ? q_bak : q_main;

endmodule

// File: rtl/lsp_chain.sv
module lsp_chain #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] up_data,
    input  logic         up_valid,
    output logic         up_stall,
    output logic [W-1:0] dn_data,
    output logic         dn_valid,
    input  logic         dn_stall
);

    localparam int NODES = STAGES + 1;

    logic [W-1:0] node_data  [NODES];
    logic         node_valid [NODES];
    logic         node_stall [NODES];

    assign node_data[0]       = up_data;
    assign node_valid[0]      = up_valid;
    assign up_stall           = node_stall[0];
    assign dn_data            = node_data[STAGES];
    assign dn_valid           = node_valid[STAGES];
    assign node_stall[STAGES] = dn_stall;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        lsp_stage #(.W(W)) u_stage (
            .clk       (clk),
            .rst       (rst),
            .in_data   (node_data[i]),
            .in_valid  (node_valid[i]),
            .in_stall  (node_stall[i]),
            .out_data  (node_data[i+1]),
            .out_valid (node_valid[i+1]),
            .out_stall (node_stall[i+1])
        );
    end

endmodule

// File: rtl/lsp_chain_chk.sv
module lsp_chain_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         up_valid,
    input logic         up_stall,
    input logic [W-1:0] dn_data,
    input logic         dn_valid,
    input logic         dn_stall
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!dn_valid && !up_stall));

    // R4
    stalled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_stall) |=> (dn_valid && $stable(dn_data)));

    // R6
    stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(up_stall) |-> $past(up_valid));

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dn_valid) |-> !$past(dn_stall));

endmodule

bind lsp_chain lsp_chain_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .up_valid (up_valid),
    .up_stall (up_stall),
    .dn_data  (dn_data),
    .dn_valid (dn_valid),
    .dn_stall (dn_stall)
);

// File: tb/lsp_chain_bench.sv
module lsp_chain_bench;

    localparam int W      = 16;
    localparam int STAGES = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] up_data = '0;
    logic         up_valid = 1'b0;
    logic         up_stall;
    logic [W-1:0] dn_data;
    logic         dn_valid;
    logic         dn_stall = 1'b0;

    int errors = 0;
    int checks = 0;
    int src_idx = 0;     // next flit to offer
    int src_lim = 0;     // offer flits while src_idx < src_lim
    int rcv_idx = 0;     // next flit expected at the output
    int stall_mode = 0;  // 0 none, 1 held, 2 random
    bit junk_en = 0;     // drive garbage while up_stall is high
    bit hold_pend = 0;
    logic [W-1:0] hold_data = '0;
    logic [15:0]  lfsr = 16'hACE1;
    bit saw_up_stall = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lsp_chain #(.W(W), .STAGES(STAGES)) u_lsp_chain (
        .clk      (clk),
        .rst      (rst),
        .up_data  (up_data),
        .up_valid (up_valid),
        .up_stall (up_stall),
        .dn_data  (dn_data),
        .dn_valid (dn_valid),
        .dn_stall (dn_stall)
    );

    function automatic logic [W-1:0] pat(input int i);
        logic [W-1:0] v;
        v = W'(i) * W'(16'h03B5);
        return v ^ W'(16'h5A5A);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock cycle: observe, drive, then account handshakes.
    task automatic step();
        @(negedge clk);
        if (hold_pend)
            check(dn_valid && dn_data == hold_data, "R4 held output", int'(dn_data), int'(hold_data));
        if (up_stall) saw_up_stall = 1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (stall_mode)
            0: dn_stall = 1'b0;
            1: dn_stall = 1'b1;
            default: dn_stall = lfsr[0] | lfsr[3];
        endcase
        if (up_stall && junk_en) begin
            up_valid = lfsr[5];
            up_data  = ~pat(src_idx);
        end else if (src_idx < src_lim) begin
            up_valid = 1'b1;
            up_data  = pat(src_idx);
        end else begin
            up_valid = 1'b0;
            up_data  = '0;
        end
        #1;
        if (dn_valid && !dn_stall) begin
            // R8 and R7: order, no duplicate, no garbage
            check(rcv_idx < src_idx && dn_data == pat(rcv_idx), "R8 order", int'(dn_data), int'(pat(rcv_idx)));
            rcv_idx++;
        end
        if (up_valid && !up_stall) src_idx++;
        hold_pend = dn_valid && dn_stall;
        hold_data = dn_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        up_valid = 1'b0;
        dn_stall = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        hold_pend = 0;
        src_lim = src_idx;
        rcv_idx = src_idx;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(!dn_valid, "R1 dn_valid after reset", int'(dn_valid), 0);
        check(!up_stall, "R1 up_stall after reset", int'(up_stall), 0);
    endtask

    task automatic t_latency();
        int n;
        stall_mode = 0;
        src_lim = src_idx + 1;
        step();
        n = 0;
        while (rcv_idx < src_lim && n < 20) begin
            step();
            n++;
        end
        check(n == STAGES, "R2 latency", n, STAGES);
    endtask

    task automatic t_stream();
        int r0;
        stall_mode = 0;
        saw_up_stall = 0;
        r0 = rcv_idx;
        src_lim = src_idx + 20;
        repeat (20 + STAGES) step();
        check(rcv_idx - r0 == 20, "R3 flits in 20+STAGES cycles", rcv_idx - r0, 20);
        check(!saw_up_stall, "R3 up_stall stayed low", int'(saw_up_stall), 0);
    endtask

    task automatic t_fill_drain();
        int s0;
        stall_mode = 1;
        s0 = src_idx;
        src_lim = src_idx + 20;
        repeat (20) step();
        check(src_idx - s0 == 2 * STAGES, "R5 flits taken under held stall", src_idx - s0, 2 * STAGES);
        check(up_stall, "R6 up_stall while full", int'(up_stall), 1);
        check(dn_valid, "R4 valid while stalled", int'(dn_valid), 1);
        stall_mode = 0;
        src_lim = src_idx;
        repeat (40) step();
        check(rcv_idx == src_idx, "R8 all drained", rcv_idx, src_idx);
        check(!up_stall, "R6 up_stall released", int'(up_stall), 0);
    endtask

    task automatic t_random();
        int n;
        stall_mode = 2;
        junk_en = 1;
        src_lim = src_idx + 300;
        n = 0;
        while (rcv_idx < src_lim && n < 5000) begin
            step();
            n++;
        end
        junk_en = 0;
        check(rcv_idx == src_lim, "R8 all received under random stall", rcv_idx, src_lim);
        check(src_idx == src_lim, "R7 no extra flit taken", src_idx, src_lim);
        stall_mode = 0;
        repeat (10) step();
        check(rcv_idx == src_idx && !dn_valid, "R8 no duplicate after drain", rcv_idx, src_idx);
        check(!up_stall, "R6 up_stall low after drain", int'(up_stall), 0);
    endtask

    task automatic t_reset_full();
        stall_mode = 1;
        src_lim = src_idx + 10;
        repeat (10) step();
        do_reset();
        stall_mode = 0;
        check(!dn_valid, "R1 dn_valid after reset while full", int'(dn_valid), 0);
        check(!up_stall, "R1 up_stall after reset while full", int'(up_stall), 0);
        repeat (5) step();
        check(!dn_valid, "R1 nothing left after reset", int'(dn_valid), 0);
    endtask

    initial begin
        t_reset_state();
        t_latency();
        t_stream();
        t_fill_drain();
        t_random();
        t_reset_full();
        t_latency();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule